// File: doc/BRIEF.md
# T1 Serial PCM Timeslot Port

This block connects one T1 line-rate serial link to a byte-wide internal interface. A frame is 193 bit periods long. The first period carries the framing bit, and 24 eight-bit timeslots follow it. On the transmit side, internal logic writes a byte and a slot number into a per-slot holding buffer. The port shifts each held byte out on the serial data pin in the right slot. On the receive side, the port samples the serial data pin, puts each eight bits back together, and delivers the byte with its slot number and a one-cycle valid strobe. The framing-bit period is skipped in both directions. Framing-pattern work belongs to a separate framer.

The serial clock and frame sync have two possible sources, chosen by `cfg_master`. In master mode the port divides the system clock to make them and drives them out. In slave mode it takes both from pins and drives its clock and sync outputs low. Two configuration bits choose the serial-clock edge used for receive sampling and the edge used for transmit launch.

A frame-position state machine drives both directions. It has three states. WAIT is entered at reset, and no data moves in it. FBIT is the framing-bit period. DATA is the payload periods, tracked by a slot counter and a bit counter. Each transition happens on a rising serial-clock edge:
- WAIT to FBIT: on the first edge in master mode, or on the first edge with sync high in slave mode.
- FBIT to DATA: when no sync is seen; the counters load slot 0, bit 0.
- DATA to DATA: to advance the counters.
- DATA to FBIT: after slot 23 bit 7, or early when sync arrives.
- FBIT to FBIT: when sync repeats.

Top module: `t1_pcm_port`

## Requirements
- R1: In master mode, `pcm_clk_o` has a period of 2*HALF_DIV system clocks. `pcm_sync_o` is high for exactly one bit period, and its rising edges are 193 bit periods apart.
- R2: Payload bits travel most significant bit first. The bit period right after the framing bit carries bit 7 of timeslot 0. A byte written for slot s comes back unchanged in slot s over a serial loop.
- R3: Receive gives exactly 24 strobes per frame, with `rx_slot` counting 0 to 23 in order. Each strobe lasts one system clock. The framing-bit period never produces a strobe.
- R4: The transmit framing-bit period carries the value of `cfg_fbit`.
- R5: If a slot starts with no byte held for it, the port sends 0xFF and pulses `tx_underrun` for one cycle. A held byte is used once and then released.
- R6: `cfg_rx_fall` and `cfg_tx_fall` each choose the edge (0 = rising, 1 = falling). Loopback data is correct for tx-rise/rx-fall, tx-fall/rx-rise and tx-rise/rx-rise.
- R7: In slave mode, `pcm_clk_o` and `pcm_sync_o` stay 0. No strobe is produced until the first sync is sampled.
- R8: In slave mode, a sync sampled anywhere other than after slot 23 bit 7 (or in WAIT) forces the framing-bit position and sets sticky `align_err`. The first sync and correctly placed syncs leave it clear.
- R9: In master mode, `pcm_sync_i` and `pcm_clk_i` have no effect. Data stays correct and `align_err` stays 0.
- R10: After reset, `pcm_txd_o` is 1, and `rx_valid`, `tx_underrun` and `align_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: generate serial clock and sync; 0: take them from pins |
| cfg_rx_fall | input | 1 | Receive sampling edge, 1 = falling |
| cfg_tx_fall | input | 1 | Transmit launch edge, 1 = falling |
| cfg_fbit | input | 1 | Value sent in the framing-bit period |
| pcm_clk_i | input | 1 | Serial bit clock in slave mode |
| pcm_sync_i | input | 1 | Frame sync in slave mode, high across the edge that opens the framing bit |
| pcm_rxd_i | input | 1 | Serial receive data |
| pcm_clk_o | output | 1 | Generated serial clock (0 in slave mode) |
| pcm_sync_o | output | 1 | Generated frame sync (0 in slave mode) |
| pcm_txd_o | output | 1 | Serial transmit data |
| tx_wr_en | input | 1 | Write strobe for a transmit byte |
| tx_wr_slot | input | 5 | Slot of the written byte; values 24 to 31 are dropped |
| tx_wr_data | input | 8 | Transmit byte |
| tx_underrun | output | 1 | One-cycle pulse when an idle byte replaces a missing one |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_slot | output | 5 | Slot of the received byte |
| rx_data | output | 8 | Received byte |
| align_err | output | 1 | Sticky flag for a sync in an unexpected position |

## Verification
Some properties are checked on every cycle: the frame-position machine moves from the framing bit to slot 0 bit 0, wraps after the last payload bit, and raises the alignment flag only after an observed sync and never drops it. The receive strobe always lasts a single cycle and names a legal slot, and an idle byte always starts with a 1 on the line. Other behaviours appear only in the bench's scenarios: exact byte values through the serial loop under the three edge pairings, frame and sync timing in master mode, underrun counts against skipped writes, the silent wait before the first slave sync, and realignment after a misplaced sync.

// File: rtl/t1p_pkg.sv
package t1p_pkg;
    localparam int SLOTS      = 24;
    localparam int SLOT_BITS  = 8;
    localparam int FRAME_BITS = 1 + SLOTS * SLOT_BITS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_FBIT = 2'd1,
        ST_DATA = 2'd2
    } frm_state_e;

    typedef struct packed {
        frm_state_e          st;
        logic [SLOT_W-1:0]   slot;
        logic [BIT_W-1:0]    bitn;
    } frm_pos_t;
endpackage

// File: rtl/t1p_clkgen.sv
module t1p_clkgen #(
    parameter int HALF_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic gen_clk
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            gen_clk <= 1'b0;
        end else if (cnt_q == CW'(HALF_DIV - 1)) begin
            cnt_q   <= '0;
            gen_clk <= ~gen_clk;
        end else begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/t1p_framer.sv
module t1p_framer
    import t1p_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     master,
    input  logic     rise,
    input  logic     sync_hit,
    output frm_pos_t cur,
    output frm_pos_t nxt,
    output logic     align_err
);
    logic last_bit;
    logic align_hit;

    assign last_bit = (cur.slot == SLOT_W'(SLOTS - 1)) && (cur.bitn == BIT_W'(SLOT_BITS - 1));

    always_comb begin
        nxt       = cur;
        align_hit = 1'b0;
        if (rise) begin
            unique case (cur.st)
                ST_WAIT: begin
                    if (master || sync_hit) nxt.st = ST_FBIT;
                end
                ST_FBIT: begin
                    if (sync_hit) begin
                        align_hit = 1'b1;
                    end else begin
                        nxt.st   = ST_DATA;
                        nxt.slot = '0;
                        nxt.bitn = '0;
                    end
                end
                ST_DATA: begin
                    if (sync_hit || last_bit) begin
                        nxt.st    = ST_FBIT;
                        align_hit = sync_hit && !last_bit;
                    end else if (cur.bitn == BIT_W'(SLOT_BITS - 1)) begin
                        nxt.bitn = '0;
                        nxt.slot = cur.slot + SLOT_W'(1);
                    end else begin
                        nxt.bitn = cur.bitn + BIT_W'(1);
                    end
                end
                default: nxt.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.st    <= ST_WAIT;
            cur.slot  <= '0;
            cur.bitn  <= '0;
            align_err <= 1'b0;
        end else begin
            cur       <= nxt;
            align_err <= align_err | align_hit;
        end
    end

    AST_SLOT0_AFTER_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == ST_FBIT && rise && !sync_hit) |=> (cur.st == ST_DATA && cur.slot == '0 && cur.bitn == '0)); // R2
    AST_WRAP_TO_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.st == ST_DATA && last_bit && rise) |=> (cur.st == ST_FBIT)); // R3
    AST_ALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_err) |-> $past(rise && sync_hit)); // R8
    AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err); // R8
endmodule

// File: rtl/t1p_tx.sv
module t1p_tx
    import t1p_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  frm_pos_t          pos,
    input  logic              fbit,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [7:0]        wr_data,
    output logic              txd,
    output logic              underrun
);
    logic [7:0]       hold_q [SLOTS];
    logic [SLOTS-1:0] full_q;
    logic [7:0]       sh_q;
    logic             load;
    logic             wr_ok;

    assign load  = launch && pos.st == ST_DATA && pos.bitn == '0;
    assign wr_ok = wr_en && (wr_slot < SLOT_W'(SLOTS));

    always_ff @(posedge clk) begin
        if (wr_ok) hold_q[wr_slot] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_ok && wr_slot == SLOT_W'(i))
                    full_q[i] <= 1'b1;
                else if (load && pos.slot == SLOT_W'(i))
                    full_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd      <= 1'b1;
            sh_q     <= 8'hFF;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (launch) begin
                unique case (pos.st)
                    ST_FBIT: txd <= fbit;
                    ST_DATA: begin
                        if (pos.bitn == '0) begin
                            if (full_q[pos.slot]) begin
                                txd  <= hold_q[pos.slot][7];
                                sh_q <= {hold_q[pos.slot][6:0], 1'b1};
                            end else begin
                                txd      <= 1'b1;
                                sh_q     <= 8'hFF;
                                underrun <= 1'b1;
                            end
                        end else begin
                            txd  <= sh_q[7];
                            sh_q <= {sh_q[6:0], 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (txd == 1'b1)); // R5
endmodule

// File: rtl/t1p_rx.sv
module t1p_rx
    import t1p_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  frm_pos_t          pos,
    input  logic              rxd,
    output logic              valid,
    output logic [SLOT_W-1:0] slot,
    output logic [7:0]        data
);
    logic [7:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            valid <= 1'b0;
            slot  <= '0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            if (sample && pos.st == ST_DATA) begin
                sh_q <= {sh_q[6:0], rxd};
                if (pos.bitn == BIT_W'(SLOT_BITS - 1)) begin
                    valid <= 1'b1;
                    slot  <= pos.slot;
                    data  <= {sh_q[6:0], rxd};
                end
            end
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R3
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (slot < SLOT_W'(SLOTS))); // R3
endmodule

// File: rtl/t1_pcm_port.sv
module t1_pcm_port
    import t1p_pkg::*;
#(
    parameter int HALF_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_master,
    input  logic       cfg_rx_fall,
    input  logic       cfg_tx_fall,
    input  logic       cfg_fbit,
    input  logic       pcm_clk_i,
    input  logic       pcm_sync_i,
    input  logic       pcm_rxd_i,
    output logic       pcm_clk_o,
    output logic       pcm_sync_o,
    output logic       pcm_txd_o,
    input  logic       tx_wr_en,
    input  logic [4:0] tx_wr_slot,
    input  logic [7:0] tx_wr_data,
    output logic       tx_underrun,
    output logic       rx_valid,
    output logic [4:0] rx_slot,
    output logic [7:0] rx_data,
    output logic       align_err
);
    logic     gen_clk;
    logic     sclk_s1, sclk_s2, sync_s1, rxd_s1;
    logic     rise, fall, sync_hit;
    frm_pos_t cur, nxt;

    t1p_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_clk (gen_clk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s1 <= 1'b0;
            sclk_s2 <= 1'b0;
            sync_s1 <= 1'b0;
            rxd_s1  <= 1'b1;
        end else begin
            sclk_s1 <= cfg_master ? gen_clk : pcm_clk_i;
            sclk_s2 <= sclk_s1;
            sync_s1 <= pcm_sync_i;
            rxd_s1  <= pcm_rxd_i;
        end
    end

    assign rise     = sclk_s1 & ~sclk_s2;
    assign fall     = ~sclk_s1 & sclk_s2;
    assign sync_hit = sync_s1 & ~cfg_master;

    t1p_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .master    (cfg_master),
        .rise      (rise),
        .sync_hit  (sync_hit),
        .cur       (cur),
        .nxt       (nxt),
        .align_err (align_err)
    );

    t1p_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (cfg_tx_fall ? fall : rise),
        .pos      (cfg_tx_fall ? cur : nxt),
        .fbit     (cfg_fbit),
        .wr_en    (tx_wr_en),
        .wr_slot  (tx_wr_slot),
        .wr_data  (tx_wr_data),
        .txd      (pcm_txd_o),
        .underrun (tx_underrun)
    );

    t1p_rx u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (cfg_rx_fall ? fall : rise),
        .pos    (cur),
        .rxd    (rxd_s1),
        .valid  (rx_valid),
        .slot   (rx_slot),
        .data   (rx_data)
    );

    assign pcm_clk_o  = cfg_master & gen_clk;
    assign pcm_sync_o = cfg_master & (cur.st == ST_FBIT);
endmodule

// File: tb/test_t1_pcm_port.sv
module test_t1_pcm_port;
    localparam int HALF = 16;
    localparam int BITP = 2 * HALF;
    localparam int HS   = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_rx_fall = 1'b1, cfg_tx_fall = 1'b0, cfg_fbit = 1'b0;
    logic       pcm_clk_i = 1'b0, pcm_sync_i = 1'b0, bench_rxd = 1'b1, loop_en = 1'b1;
    logic       pcm_rxd_i, pcm_clk_o, pcm_sync_o, pcm_txd_o;
    logic       tx_wr_en = 1'b0;
    logic [4:0] tx_wr_slot = '0;
    logic [7:0] tx_wr_data = '0;
    logic       tx_underrun, rx_valid, align_err;
    logic [4:0] rx_slot;
    logic [7:0] rx_data;

    assign pcm_rxd_i = loop_en ? pcm_txd_o : bench_rxd;

    t1_pcm_port #(.HALF_DIV(HALF)) i_t1_pcm_port (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_rx_fall(cfg_rx_fall),
        .cfg_tx_fall(cfg_tx_fall), .cfg_fbit(cfg_fbit), .pcm_clk_i(pcm_clk_i),
        .pcm_sync_i(pcm_sync_i), .pcm_rxd_i(pcm_rxd_i), .pcm_clk_o(pcm_clk_o),
        .pcm_sync_o(pcm_sync_o), .pcm_txd_o(pcm_txd_o), .tx_wr_en(tx_wr_en),
        .tx_wr_slot(tx_wr_slot), .tx_wr_data(tx_wr_data), .tx_underrun(tx_underrun),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data), .align_err(align_err)
    );

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;
    bit mon_master = 0;
    int exp_slot, strobes, under_cnt, exp_under, last_rise, high_start, run_bad;
    logic prev_sync, prev_txd, prev_valid;
    logic [7:0] pend [24];
    bit         skipped [24];
    logic [7:0] sd [24];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Expected serial bit for bit period p of a slave frame (0 = framing bit)
    function automatic logic frame_bit(input int p, input logic fb);
        if (p == 0) return fb;
        return sd[(p - 1) / 8][7 - ((p - 1) % 8)];
    endfunction

    task automatic tick();
        logic [7:0] expd;
        int s;
        @(negedge clk);
        cyc++;
        tx_wr_en = 1'b0;
        if (cfg_master) begin
            pcm_sync_i = 1'($urandom_range(0, 1));   // R9 noise on unused pins
            pcm_clk_i  = 1'($urandom_range(0, 1));
        end
        if (tx_underrun) under_cnt++;
        if (mon_master) begin
            if (pcm_sync_o && !prev_sync) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == 193 * BITP, "R1", "frame period", cyc - last_rise, 193 * BITP);
                last_rise  = cyc;
                high_start = cyc;
            end
            if (!pcm_sync_o && prev_sync && high_start >= 0) begin
                chk(cyc - high_start == BITP, "R1", "sync width", cyc - high_start, BITP);
                chk(prev_txd == cfg_fbit, "R4", "framing bit on line", int'(prev_txd), int'(cfg_fbit));
            end
        end
        if (rx_valid) begin
            strobes++;
            s = int'(rx_slot);
            chk(!prev_valid, "R3", "strobe width", int'(prev_valid), 0);
            chk(s == exp_slot, "R3", "slot order", s, exp_slot);
            if (s < 24) begin
                if (mon_master) begin
                    expd = skipped[s] ? 8'hFF : pend[s];
                    if (rx_data != expd) run_bad++;
                    chk(rx_data == expd, skipped[s] ? "R5" : "R2", "loop byte", int'(rx_data), int'(expd));
                    if (skipped[s]) exp_under++;
                    if (s == 23) chk(under_cnt == exp_under, "R5", "underrun pulses", under_cnt, exp_under);
                    if ($urandom_range(0, 4) == 0) begin
                        skipped[s] = 1;
                    end else begin
                        skipped[s] = 0;
                        pend[s]    = 8'($urandom);
                        tx_wr_en   = 1'b1;
                        tx_wr_slot = 5'(s);
                        tx_wr_data = pend[s];
                    end
                end else begin
                    chk(rx_data == sd[s], "R2", "slave byte", int'(rx_data), int'(sd[s]));
                    chk(pcm_clk_o == 1'b0 && pcm_sync_o == 1'b0, "R7", "outputs quiet", int'({pcm_clk_o, pcm_sync_o}), 0);
                end
            end
            exp_slot = (exp_slot + 1) % 24;
        end
        prev_sync  = pcm_sync_o;
        prev_txd   = pcm_txd_o;
        prev_valid = rx_valid;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_slot = 0; strobes = 0; under_cnt = 0; exp_under = 0;
        last_rise = -1; high_start = -1; run_bad = 0;
        prev_sync = 1'b0; prev_txd = 1'b1; prev_valid = 1'b0;
    endtask

    task automatic run_master(input logic rxf, input logic txf, input logic fb);
        cfg_master = 1'b1; cfg_rx_fall = rxf; cfg_tx_fall = txf; cfg_fbit = fb;
        loop_en = 1'b1; mon_master = 1'b0;
        do_reset();
        mon_master = 1'b1;
        for (int s = 0; s < 24; s++) begin
            pend[s] = 8'($urandom);
            skipped[s] = 0;
            tick();
            tx_wr_en = 1'b1; tx_wr_slot = 5'(s); tx_wr_data = pend[s];
        end
        // directed corner values in the first frame
        pend[0] = 8'h80; pend[23] = 8'h01;
        tick(); tx_wr_en = 1'b1; tx_wr_slot = 5'd0;  tx_wr_data = 8'h80;
        tick(); tx_wr_en = 1'b1; tx_wr_slot = 5'd23; tx_wr_data = 8'h01;
        while (strobes < 96 && cyc < 190000) tick();
        chk(strobes == 96, "R3", "strobes seen", strobes, 96);
        chk(run_bad == 0, "R6", "loop errors for edge setting", run_bad, 0);
        chk(align_err == 1'b0, "R9", "align_err in master", int'(align_err), 0);
        mon_master = 1'b0;
    endtask

    task automatic slave_bit(input logic d, input logic s);
        tick();
        pcm_clk_i = 1'b0; bench_rxd = d; pcm_sync_i = s;
        repeat (HS - 1) tick();
        tick();
        pcm_clk_i = 1'b1;
        repeat (HS - 1) tick();
    endtask

    task automatic slave_frame(input bit inject, input int at);
        logic fb;
        for (int i = 0; i < 24; i++) sd[i] = 8'($urandom);
        sd[0] = 8'hA5;
        fb = 1'($urandom_range(0, 1));
        for (int p = 0; p < 193; p++) begin
            if (inject && p == at) begin
                slave_bit(frame_bit(p, fb), 1'b1);
                return;
            end
            slave_bit(frame_bit(p, fb), p == 192);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R10 reset state
        do_reset();
        chk(pcm_txd_o == 1'b1, "R10", "txd after reset", int'(pcm_txd_o), 1);
        chk(rx_valid == 1'b0 && tx_underrun == 1'b0, "R10", "strobes after reset", int'({rx_valid, tx_underrun}), 0);
        chk(align_err == 1'b0, "R10", "align_err after reset", int'(align_err), 0);

        run_master(1'b1, 1'b0, 1'b1);   // R6 tx rise / rx fall
        run_master(1'b0, 1'b1, 1'b0);   // R6 tx fall / rx rise
        run_master(1'b0, 1'b0, 1'b1);   // R6 tx rise / rx rise

        // Slave mode
        cfg_master = 1'b0; cfg_rx_fall = 1'b0; cfg_tx_fall = 1'b0; loop_en = 1'b0;
        pcm_clk_i = 1'b0; pcm_sync_i = 1'b0;
        do_reset();
        chk(pcm_clk_o == 1'b0 && pcm_sync_o == 1'b0, "R7", "slave outputs", int'({pcm_clk_o, pcm_sync_o}), 0);
        for (int i = 0; i < 10; i++) slave_bit(1'($urandom_range(0, 1)), 1'b0);
        chk(strobes == 0, "R7", "strobes before first sync", strobes, 0);
        slave_bit(1'b1, 1'b1);
        chk(align_err == 1'b0, "R8", "first sync", int'(align_err), 0);
        exp_slot = 0;
        for (int f = 0; f < 3; f++) slave_frame(1'b0, 0);
        chk(align_err == 1'b0, "R8", "aligned syncs", int'(align_err), 0);
        chk(strobes == 72, "R3", "strobes in 3 frames", strobes, 72);
        slave_frame(1'b1, 50);
        chk(align_err == 1'b1, "R8", "misplaced sync", int'(align_err), 1);
        exp_slot = 0;
        for (int f = 0; f < 2; f++) slave_frame(1'b0, 0);
        chk(align_err == 1'b1, "R8", "flag sticky", int'(align_err), 1);
        chk(strobes == 72 + 6 + 48, "R3", "strobes after realign", strobes, 126);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule